// File: doc/BRIEF.md
# Programmable TDM Time-Slot Port

This block attaches to a serial time-division-multiplexed bus that is paced by a data clock and framed by a frame-sync line. Software picks one slot in each frame to receive and one slot to transmit, through two slot registers. The block counts bit periods from the start of each frame. It shifts in the bits of the selected receive slot and hands them out as a parallel word with a one-cycle strobe. In the selected transmit slot it serialises a parallel word onto the output pin with the output enable asserted. In every other bit period the enable is low, so an external pad can tri-state the line.

A mode input sets the slot geometry. In narrow mode a frame holds 64 slots of 4 bits each. In wide mode it holds 32 slots of 8 bits each. The frame length is the same in both modes, so the layout does not depend on the payload bit rate. The data clock and frame sync are sampled by the block's own system clock, which must run at least four times faster than the data clock. Received bits are taken on the falling data-clock edge, and transmitted bits change on the rising edge.

Top module: `tdm_slot_port`

## Requirements
- R1: While reset is active, and right after it, `sdout_en`, `sdout`, `rx_valid`, `tx_load` and `rx_word` are all zero.
- R2: Bit period 0 of a frame starts at the first rising `bclk` edge after a rising edge of `fsync`. Each later rising edge starts the next bit period.
- R3: When `wide_mode` is 0, slot n occupies bit periods 4n to 4n+3, and n is taken from slot-register bits 5..0 (range 0 to 63).
- R4: When `wide_mode` is 1, slot n occupies bit periods 8n to 8n+7, and n is taken from slot-register bits 4..0. Bit 5 is ignored.
- R5: Slot-register bits 7 and 6 have no effect on either lane.
- R6: `sdout_en` is 1 exactly during the bit periods of the transmit slot. Whenever `sdout_en` is 0, `sdout` is 0. Both change only after a rising `bclk` edge.
- R7: The transmit slot is sent most significant bit first. Narrow mode sends `tx_word[3:0]` and wide mode sends `tx_word[7:0]`.
- R8: During the receive slot, `sdin` is sampled on each falling `bclk` edge, most significant bit first. Narrow mode places the result in `rx_word[3:0]` with the upper bits zero. `sdin` outside the receive slot has no effect on `rx_word`.
- R9: `rx_valid` is a single system-clock pulse, issued once per frame right after the last bit of the receive slot is sampled. `rx_word` holds the new value from that pulse onward.
- R10: `tx_word` is captured at the first bit of the transmit slot, and `tx_load` pulses for one cycle at the same time. Changes to `tx_word` after that point do not alter the bits of the slot being sent.
- R11: A new frame sync restarts the bit count even if the previous frame was shorter than 256 bit periods. Slots that were never reached produce no strobe and no output.
- R12: After bit period 255 the counter stops. Further `bclk` edges before the next frame sync drive no output and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial data clock |
| fsync | input | 1 | Frame sync; its rising edge arms the frame start |
| sdin | input | 1 | Serial receive data |
| wide_mode | input | 1 | 0: 4-bit slots, 64 per frame; 1: 8-bit slots, 32 per frame |
| rx_slot | input | 8 | Receive slot register |
| tx_slot | input | 8 | Transmit slot register |
| tx_word | input | 8 | Parallel word to send in the transmit slot |
| sdout | output | 1 | Serial transmit data |
| sdout_en | output | 1 | Output enable for the serial pad |
| tx_load | output | 1 | Pulse when `tx_word` is captured |
| rx_word | output | 8 | Last received slot word |
| rx_valid | output | 1 | Pulse when `rx_word` is updated |

## Verification
The bench walks frames that cover both slot widths, the first and last slots, slot registers with reserved or ignored bits set, a frame cut short before its receive slot, and a frame that runs past 256 bit periods. A counter that is off by one from the frame-sync edge shifts every received word and misplaces the output window. A counter that wraps instead of stopping reopens slot 0 at bit 256. A decoder that keeps the reserved bits or the unused upper bit of the slot number never matches, and the strobe goes missing. The bench also changes `tx_word` in the middle of a slot, which exposes a transmitter that reads the live word instead of its captured copy.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic {
    SLOT_NARROW = 1'b0,
    SLOT_WIDE   = 1'b1
  } slot_mode_e;

  // Edge events seen on the sampled serial bus in one system cycle
  typedef struct packed {
    logic rise;
    logic fall;
  } bus_evt_t;

  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
  localparam int LANES   = 2;

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  output bus_evt_t         evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             live_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             live_d
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic bclk_q;
  logic fs_q;
  logic armed_q, armed_d;
  logic fs_rise;

  always_comb begin
    evt.rise = bclk & ~bclk_q;
    evt.fall = ~bclk & bclk_q;
    fs_rise  = fsync & ~fs_q;
  end

  // Next-state: frame sync arms, the following rising edge opens bit 0
  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    live_d  = live_q;
    if (fs_rise) begin
      armed_d = 1'b1;
    end
    if (evt.rise) begin
      if (armed_q || fs_rise) begin
        cnt_d   = '0;
        live_d  = 1'b1;
        armed_d = 1'b0;
      end else if (live_q) begin
        if (cnt_q == LAST_BIT) begin
          live_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      live_q  <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      fs_q    <= fsync;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      live_q  <= live_d;
    end
  end

endmodule

// File: rtl/tdm_slot_dec.sv
module tdm_slot_dec
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int WORD_W     = 8,
  parameter int SLOT_REG_W = 8,
  localparam int CNT_W    = $clog2(FRAME_BITS),
  localparam int NARROW_W = WORD_W / 2,
  localparam int NLOG     = $clog2(NARROW_W),
  localparam int WLOG     = NLOG + 1,
  localparam int NUM_W    = CNT_W - NLOG,
  localparam int POS_W    = WLOG
) (
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  live,
  input  slot_mode_e            mode,
  input  logic [SLOT_REG_W-1:0] slot_reg,
  output logic                  hit,
  output logic                  first,
  output logic                  last,
  output logic [POS_W-1:0]      bit_sel
);

  logic [POS_W-1:0] pos;
  logic             unused_rsvd;

  // Bits above the slot-number field are reserved
  assign unused_rsvd = ^slot_reg[SLOT_REG_W-1:NUM_W];

  always_comb begin
    if (mode == SLOT_WIDE) begin
      hit     = live && (cnt[CNT_W-1:WLOG] == slot_reg[NUM_W-2:0]);
      pos     = cnt[WLOG-1:0];
      last    = (pos == POS_W'(WORD_W - 1));
      bit_sel = POS_W'(WORD_W - 1) - pos;
    end else begin
      hit     = live && (cnt[CNT_W-1:NLOG] == slot_reg[NUM_W-1:0]);
      pos     = {1'b0, cnt[NLOG-1:0]};
      last    = (pos == POS_W'(NARROW_W - 1));
      bit_sel = POS_W'(NARROW_W - 1) - pos;
    end
    first = (pos == '0);
  end

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int NARROW_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              hit,
  input  logic              last,
  input  slot_mode_e        mode,
  input  logic              sdin,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_d;
  logic              valid_d;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], sdin};

  always_comb begin
    sh_d    = sh_q;
    word_d  = rx_word;
    valid_d = 1'b0;
    if (fall && hit) begin
      sh_d = sh_next;
      if (last) begin
        valid_d = 1'b1;
        if (mode == SLOT_WIDE) begin
          word_d = sh_next;
        end else begin
          word_d = {{(WORD_W-NARROW_W){1'b0}}, sh_next[NARROW_W-1:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      rx_word  <= word_d;
      rx_valid <= valid_d;
    end
  end

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              hit,
  input  logic              first,
  input  logic [POS_W-1:0]  bit_sel,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdout,
  output logic              sdout_en,
  output logic              tx_load
);

  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              sdout_d, en_d, load_d;

  always_comb begin
    shadow_d = shadow_q;
    sdout_d  = sdout;
    en_d     = sdout_en;
    load_d   = 1'b0;
    if (rise) begin
      if (hit) begin
        en_d = 1'b1;
        if (first) begin
          shadow_d = tx_word;
          sdout_d  = tx_word[bit_sel];
          load_d   = 1'b1;
        end else begin
          sdout_d = shadow_q[bit_sel];
        end
      end else begin
        en_d    = 1'b0;
        sdout_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      sdout    <= 1'b0;
      sdout_en <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      sdout    <= sdout_d;
      sdout_en <= en_d;
      tx_load  <= load_d;
    end
  end

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int WORD_W     = 8,
  parameter int SLOT_REG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bclk,
  input  logic                  fsync,
  input  logic                  sdin,
  input  logic                  wide_mode,
  input  logic [SLOT_REG_W-1:0] rx_slot,
  input  logic [SLOT_REG_W-1:0] tx_slot,
  input  logic [WORD_W-1:0]     tx_word,
  output logic                  sdout,
  output logic                  sdout_en,
  output logic                  tx_load,
  output logic [WORD_W-1:0]     rx_word,
  output logic                  rx_valid
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int POS_W = $clog2(WORD_W);

  bus_evt_t         evt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             live_q, live_d;
  slot_mode_e       mode;

  logic [CNT_W-1:0]      lane_cnt  [LANES];
  logic                  lane_live [LANES];
  logic [SLOT_REG_W-1:0] lane_reg  [LANES];
  logic                  lane_hit  [LANES];
  logic                  lane_first[LANES];
  logic                  lane_last [LANES];
  logic [POS_W-1:0]      lane_sel  [LANES];

  assign mode = slot_mode_e'(wide_mode);

  tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk   (bclk),
    .fsync  (fsync),
    .evt    (evt),
    .cnt_q  (cnt_q),
    .live_q (live_q),
    .cnt_d  (cnt_d),
    .live_d (live_d)
  );

  // Receive lane decodes the settled count (falling edge), transmit lane
  // decodes the count being loaded on the rising edge.
  assign lane_cnt[LANE_RX]  = cnt_q;
  assign lane_live[LANE_RX] = live_q;
  assign lane_reg[LANE_RX]  = rx_slot;
  assign lane_cnt[LANE_TX]  = cnt_d;
  assign lane_live[LANE_TX] = live_d;
  assign lane_reg[LANE_TX]  = tx_slot;

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    tdm_slot_dec #(
      .FRAME_BITS (FRAME_BITS),
      .WORD_W     (WORD_W),
      .SLOT_REG_W (SLOT_REG_W)
    ) u_dec (
      .cnt      (lane_cnt[g]),
      .live     (lane_live[g]),
      .mode     (mode),
      .slot_reg (lane_reg[g]),
      .hit      (lane_hit[g]),
      .first    (lane_first[g]),
      .last     (lane_last[g]),
      .bit_sel  (lane_sel[g])
    );
  end

  logic unused_lane;
  assign unused_lane = lane_first[LANE_RX] ^ (^lane_sel[LANE_RX]) ^ lane_last[LANE_TX];

  tdm_rx_lane #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (evt.fall),
    .hit      (lane_hit[LANE_RX]),
    .last     (lane_last[LANE_RX]),
    .mode     (mode),
    .sdin     (sdin),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  tdm_tx_lane #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (evt.rise),
    .hit      (lane_hit[LANE_TX]),
    .first    (lane_first[LANE_TX]),
    .bit_sel  (lane_sel[LANE_TX]),
    .tx_word  (tx_word),
    .sdout    (sdout),
    .sdout_en (sdout_en),
    .tx_load  (tx_load)
  );

endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic sdout,
  input logic sdout_en,
  input logic tx_load,
  input logic rx_valid
);

  logic bclk_d;
  logic rise_c, fall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk;
  end

  assign rise_c = bclk & ~bclk_d;
  assign fall_c = ~bclk & bclk_d;

  // R9
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  rx_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall_c));

  // R6
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdout_en |-> !sdout);

  // R6
  en_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_en) |-> $past(rise_c));

  // R10
  window_opens_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdout_en) |-> tx_load);

  // R10
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

endmodule

bind tdm_slot_port tdm_slot_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bclk     (bclk),
  .sdout    (sdout),
  .sdout_en (sdout_en),
  .tx_load  (tx_load),
  .rx_valid (rx_valid)
);

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic       sdin = 1'b0;
  logic       wide_mode = 1'b0;
  logic [7:0] rx_slot = '0;
  logic [7:0] tx_slot = '0;
  logic [7:0] tx_word = '0;
  logic       sdout, sdout_en, tx_load, rx_valid;
  logic [7:0] rx_word;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int lcnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tdm_slot_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .wide_mode(wide_mode), .rx_slot(rx_slot), .tx_slot(tx_slot),
    .tx_word(tx_word), .sdout(sdout), .sdout_en(sdout_en),
    .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) vcnt++;
    if (tx_load)  lcnt++;
  end

  // {wide, rx_slot, tx_slot, tx_word, seed, nbits}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 8'h05, 8'h09, 8'hA5, 8'h3C, 16'd256},  // R3 R7 R8
    {1'b1, 8'h03, 8'h1F, 8'hC3, 8'h5A, 16'd256},  // R4 last wide slot
    {1'b0, 8'hC5, 8'h7F, 8'h0E, 8'h96, 16'd256},  // R5 reserved bits, slot 63
    {1'b1, 8'h25, 8'h20, 8'h81, 8'h11, 16'd256},  // R4 bit 5 ignored
    {1'b0, 8'h3F, 8'h00, 8'h09, 8'h77, 16'd100},  // R11 short frame
    {1'b0, 8'h02, 8'h03, 8'h06, 8'hE1, 16'd256},  // R11 restart
    {1'b0, 8'h00, 8'h00, 8'h0B, 8'h2D, 16'd264},  // R12 overrun
    {1'b1, 8'h00, 8'h01, 8'hFF, 8'hB4, 16'd256}   // R2 slot 0 alignment
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic din_of(input int k, input logic [7:0] seed);
    return seed[k & 7] ^ k[3];
  endfunction

  task automatic run_frame(input logic [48:0] v);
    logic       wd;
    logic [7:0] txw;
    logic [7:0] seed;
    int n, w, rs, ts, bad, bad_act, bad_exp;
    logic [7:0] exp_rx;
    bit rx_reached, tx_reached;
    wd   = v[48];
    txw  = v[31:24];
    seed = v[23:16];
    n    = int'(v[15:0]);
    w    = wd ? 8 : 4;
    rs   = wd ? int'(v[44:40]) : int'(v[45:40]);
    ts   = wd ? int'(v[36:32]) : int'(v[37:32]);
    rx_reached = (rs * w + w) <= n;
    tx_reached = (ts * w) < n;
    exp_rx = '0;
    for (int i = 0; i < w; i++) exp_rx = {exp_rx[6:0], din_of(rs * w + i, seed)};
    @(negedge clk);
    wide_mode = wd; rx_slot = v[47:40]; tx_slot = v[39:32]; tx_word = txw;
    vcnt = 0; lcnt = 0; bad = 0; bad_act = 0; bad_exp = 0;
    fsync = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic exp_en, exp_b;
      exp_en = (k < 256) && (k / w == ts);
      exp_b  = exp_en ? txw[w - 1 - (k % w)] : 1'b0;
      bclk = 1'b1;
      repeat (3) @(negedge clk);
      if (k == 0) fsync = 1'b0;
      if (sdout_en !== exp_en || sdout !== exp_b) begin
        if (bad == 0) begin
          bad_act = {30'd0, sdout_en, sdout};
          bad_exp = {30'd0, exp_en, exp_b};
        end
        bad++;
      end
      // R10: the live word changes after capture; the slot must not follow it
      if (exp_en && (k % w == 0)) tx_word = ~txw;
      @(negedge clk);
      bclk = 1'b0;
      sdin = din_of(k, seed);
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(bad == 0, "R2/R6/R7 output window and bits", bad_act, bad_exp);
    check(lcnt == (tx_reached ? 1 : 0), "R10/R11/R12 tx_load count", lcnt, tx_reached ? 1 : 0);
    check(vcnt == (rx_reached ? 1 : 0), "R9/R11/R12 rx_valid count", vcnt, rx_reached ? 1 : 0);
    if (rx_reached)
      check(rx_word === exp_rx, "R3/R4/R5/R8 rx_word", rx_word, exp_rx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sdout_en === 1'b0 && sdout === 1'b0, "R1 output idle in reset", sdout_en, 0);
    check(rx_valid === 1'b0 && tx_load === 1'b0, "R1 strobes low in reset", rx_valid, 0);
    check(rx_word === 8'h00, "R1 rx_word cleared", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdout_en === 1'b0 && rx_valid === 1'b0, "R1 idle after reset", sdout_en, 0);

    for (int i = 0; i < 8; i++) run_frame(VEC[i]);

    // R12: extra clocks with no frame sync leave the port silent
    vcnt = 0; lcnt = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); bclk = 1'b1; repeat (3) @(negedge clk);
      @(negedge clk); bclk = 1'b0; repeat (3) @(negedge clk);
    end
    check(sdout_en === 1'b0 && vcnt == 0 && lcnt == 0, "R12 silent without frame sync",
          vcnt + lcnt, 0);

    // R1: reset in mid-operation clears the received word
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(rx_word === 8'h00 && sdout_en === 1'b0, "R1 reset mid-run", rx_word, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule